// File: doc/BRIEF.md
# Subcarrier-Locked Line Reference Divider

This block derives a line-rate reference from a four-times-subcarrier clock and compares it with a line reference taken from the master pixel clock. The comparator output goes to an external loop filter and VCO, so the loop pulls the master clock into lock with the subcarrier. This is needed in the two PAL variants, where the subcarrier and the line rate are not in a simple integer ratio to the master clock. In PAL the subcarrier holds 1135 cycles per line plus two extra cycles per field. A pulse eliminator in front of the divider chain removes those surplus pulses, so a 7 x 81 x 2 chain produces a clean line reference from 1134 passed pulses. In PAL-M the chain is 9 x 101 = 909 and nothing is removed.

Both clock domains reach the block as single-cycle enable strobes on one system clock: `sc_en` for the subcarrier and `mc_en` for the master clock. The system mode selects the chain lengths and the master line length (908 in PAL, 910 in PAL-M). In NTSC and SECAM no loop is needed, so the block stays idle. An external-sync input freezes every counter. A colour-frame reset pulse restarts the subcarrier side at a fixed field, which makes the sync-to-subcarrier phase repeatable. The comparator is modelled as a three-state pad: a drive value plus an output enable.

Top module: `sclk_line_divider`

## Requirements
- R1: With `sys_mode` = 2'b10 (PAL-M), `sc_line_ref` pulses once for every 909 accepted `sc_en` strobes. It rises one clock after the enable that completes the count, and no strobe is removed.
- R2: With `sys_mode` = 2'b11 (PAL), 1134 strobes are counted per line. The first `sc_en` after every line completion is removed, so consecutive `sc_line_ref` pulses are 1135 strobes apart.
- R3: In PAL, each completion of the last line of a field (default field length 312 lines, set by `FIELD_LINES`) is followed by two further removed strobes. That line interval is 1137 strobes.
- R4: `mc_line_ref` pulses once every 908 `mc_en` strobes in PAL and once every 910 in PAL-M.
- R5: A one-cycle `cf_reset` clears the subcarrier-side counters, the pending removals and the field line index. The next `sc_line_ref` then follows after exactly 1134 (PAL) or 909 (PAL-M) accepted strobes, with no removal first.
- R6: While `ext_sync` is high, both sides hold their counts, no reference pulses appear, and `pd_oe` is low from the next clock on. After release, counting continues from the held values.
- R7: When a subcarrier reference arrives while the comparator is idle and no master reference arrives in the same cycle, it drives `pd_oe`=1 and `pd_drive`=1 until the next master reference. The opposite order drives `pd_oe`=1 and `pd_drive`=0 until the next subcarrier reference. Simultaneous references leave it idle. The outputs change in the same cycle as the reference pulse that causes the change.
- R8: With `sys_mode` = 2'b00 (NTSC) or 2'b01 (SECAM), no reference pulses appear, `pd_oe` is low, and all counters are held at zero. A later switch to a PLL mode therefore starts from a full line.
- R9: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both domains arrive as enables on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_mode | input | 2 | 00 NTSC, 01 SECAM, 10 PAL-M, 11 PAL |
| ext_sync | input | 1 | High freezes the loop counters and idles the comparator |
| cf_reset | input | 1 | Colour-frame restart of the subcarrier side |
| sc_en | input | 1 | One strobe per four-times-subcarrier cycle |
| mc_en | input | 1 | One strobe per master clock cycle |
| sc_line_ref | output | 1 | Line reference derived from the subcarrier |
| mc_line_ref | output | 1 | Line reference derived from the master clock |
| pd_drive | output | 1 | Comparator level when enabled (1 = raise VCO) |
| pd_oe | output | 1 | Comparator output enable; low means high impedance |

## Verification
The assertions assume that `sys_mode` holds steady across a line completion whenever the removal rule is checked. They also assume that `sc_en` and `mc_en` are plain one-cycle strobes sampled on the same clock, and that `cf_reset` and `ext_sync` are driven synchronously. The stimulus changes the mode only together with a colour-frame reset or after an idle NTSC interval. It holds `ext_sync` for whole windows of clocks, and it generates both strobes from fixed-step phase counters that change only between clock edges.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  typedef enum logic [1:0] {
    SYS_NTSC  = 2'b00,
    SYS_SECAM = 2'b01,
    SYS_PALM  = 2'b10,
    SYS_PAL   = 2'b11
  } sys_mode_e;

  typedef enum logic [1:0] {
    PD_IDLE = 2'b00,
    PD_UP   = 2'b01,
    PD_DN   = 2'b10
  } pd_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Strobes to remove after a completed line.
  function automatic int drops_after_line(input logic pal, input logic field_end,
                                          input int extra);
    int n;
    n = 0;
    if (pal) n = field_end ? (1 + extra) : 1;
    return n;
  endfunction

  // Next comparator state from the two reference edges.
  function automatic pd_state_e pd_next(input pd_state_e s, input logic sc,
                                        input logic mc);
    pd_state_e n;
    n = PD_IDLE;
    case (s)
      PD_IDLE: begin
        if (sc && !mc)      n = PD_UP;
        else if (mc && !sc) n = PD_DN;
        else                n = PD_IDLE;
      end
      PD_UP:   n = mc ? PD_IDLE : PD_UP;
      PD_DN:   n = sc ? PD_IDLE : PD_DN;
      default: n = PD_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sclk_stage.sv
module sclk_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic         wrap
);
  logic [W-1:0] cnt;

  // >= so a count left over from a longer mode still wraps.
  assign wrap = step && !clr && (cnt >= lim - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= wrap ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/sclk_swallow.sv
module sclk_swallow #(
  parameter int FIELD_LINES = 312,
  parameter int FIELD_EXTRA = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en_in,
  input  logic pal,
  input  logic line_done,
  output logic pass
);
  import sclk_pkg::*;

  localparam int LW = (FIELD_LINES > 1) ? $clog2(FIELD_LINES) : 1;
  localparam int DW = $clog2(FIELD_EXTRA + 2);

  logic [DW-1:0] drop_left;
  logic [LW-1:0] line_idx;
  logic          field_end;
  logic          swallow;

  assign field_end = (line_idx == LW'(FIELD_LINES - 1));
  assign swallow   = en_in && pal && (drop_left != '0);
  assign pass      = en_in && !swallow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_left <= '0;
      line_idx  <= '0;
    end else if (clr) begin
      drop_left <= '0;
      line_idx  <= '0;
    end else if (swallow) begin
      drop_left <= drop_left - DW'(1);
    end else if (line_done && pal) begin
      drop_left <= DW'(drops_after_line(pal, field_end, FIELD_EXTRA));
      line_idx  <= field_end ? '0 : line_idx + LW'(1);
    end
  end
endmodule

// File: rtl/sclk_phase_cmp.sv
module sclk_phase_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sc_edge,
  input  logic mc_edge,
  output logic pd_drive,
  output logic pd_oe
);
  import sclk_pkg::*;

  pd_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= PD_IDLE;
    else if (!enable) state <= PD_IDLE;
    else              state <= pd_next(state, sc_edge, mc_edge);
  end

  assign pd_oe    = (state != PD_IDLE);
  assign pd_drive = (state == PD_UP);
endmodule

// File: rtl/sclk_line_divider.sv
module sclk_line_divider #(
  parameter int PAL_DIV_A    = 7,
  parameter int PAL_DIV_B    = 81,
  parameter int PAL_DIV_C    = 2,
  parameter int PALM_DIV_A   = 9,
  parameter int PALM_DIV_B   = 101,
  parameter int PALM_DIV_C   = 1,
  parameter int PAL_MC_LINE  = 908,
  parameter int PALM_MC_LINE = 910,
  parameter int FIELD_LINES  = 312,
  parameter int FIELD_EXTRA  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sys_mode,
  input  logic       ext_sync,
  input  logic       cf_reset,
  input  logic       sc_en,
  input  logic       mc_en,
  output logic       sc_line_ref,
  output logic       mc_line_ref,
  output logic       pd_drive,
  output logic       pd_oe
);
  import sclk_pkg::*;

  localparam int NSTAGE  = 3;
  localparam int STG_MAX = max2(max2(max2(PAL_DIV_A, PAL_DIV_B), max2(PAL_DIV_C, PALM_DIV_A)),
                                max2(PALM_DIV_B, PALM_DIV_C));
  localparam int STG_W   = $clog2(STG_MAX + 1);
  localparam int MC_W    = $clog2(max2(PAL_MC_LINE, PALM_MC_LINE) + 1);
  localparam int PAL_LIM  [NSTAGE] = '{PAL_DIV_A, PAL_DIV_B, PAL_DIV_C};
  localparam int PALM_LIM [NSTAGE] = '{PALM_DIV_A, PALM_DIV_B, PALM_DIV_C};

  sys_mode_e mode;
  logic is_pal, pll_on, run;
  logic sc_clr, sc_pass, sc_line, mc_line, mc_step;
  logic [NSTAGE:0] stage_step;
  logic [MC_W-1:0] mc_lim;

  assign mode    = sys_mode_e'(sys_mode);
  assign is_pal  = (mode == SYS_PAL);
  assign pll_on  = (mode == SYS_PAL) || (mode == SYS_PALM);
  assign run     = pll_on && !ext_sync;
  assign sc_clr  = !pll_on || cf_reset;
  assign mc_step = mc_en && run;

  // Pulse eliminator in front of the subcarrier chain
  sclk_swallow #(
    .FIELD_LINES(FIELD_LINES),
    .FIELD_EXTRA(FIELD_EXTRA)
  ) u_swallow (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sc_clr || !is_pal),
    .en_in    (sc_en && run),
    .pal      (is_pal),
    .line_done(sc_line),
    .pass     (sc_pass)
  );

  assign stage_step[0] = sc_pass;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    logic [STG_W-1:0] lim;
    assign lim = is_pal ? STG_W'(PAL_LIM[i]) : STG_W'(PALM_LIM[i]);
    sclk_stage #(.W(STG_W)) u_stg (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (sc_clr),
      .step (stage_step[i]),
      .lim  (lim),
      .wrap (stage_step[i+1])
    );
  end

  assign sc_line = stage_step[NSTAGE];

  // Master-clock line divider
  assign mc_lim = is_pal ? MC_W'(PAL_MC_LINE) : MC_W'(PALM_MC_LINE);

  sclk_stage #(.W(MC_W)) u_mc_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!pll_on),
    .step (mc_step),
    .lim  (mc_lim),
    .wrap (mc_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_line_ref <= 1'b0;
      mc_line_ref <= 1'b0;
    end else begin
      sc_line_ref <= sc_line;
      mc_line_ref <= mc_line;
    end
  end

  sclk_phase_cmp u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (run),
    .sc_edge (sc_line),
    .mc_edge (mc_line),
    .pd_drive(pd_drive),
    .pd_oe   (pd_oe)
  );

endmodule

// File: rtl/sclk_line_divider_chk.sv
module sclk_line_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] sys_mode,
  input logic       ext_sync,
  input logic       cf_reset,
  input logic       sc_en,
  input logic       sc_pass,
  input logic       mc_line,
  input logic       sc_line_ref,
  input logic       mc_line_ref,
  input logic       pd_drive,
  input logic       pd_oe
);
  logic chk_run;
  assign chk_run = sys_mode[1] && !ext_sync;

  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode[1] == 1'b0) |=> (!pd_oe && !sc_line_ref && !mc_line_ref));

  assert_ext_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync |=> (!pd_oe && !sc_line_ref && !mc_line_ref));

  assert_line_swallow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_mode == 2'b11 && $stable(sys_mode) && sc_line_ref && sc_en
     && !ext_sync && !cf_reset) |-> !sc_pass);

  assert_up_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_oe && pd_drive && !mc_line && chk_run) |=> (pd_oe && pd_drive));

  assert_up_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_oe && pd_drive && mc_line) |=> !pd_oe);

  assert_cf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cf_reset |=> !sc_line_ref);
endmodule

bind sclk_line_divider sclk_line_divider_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sys_mode   (sys_mode),
  .ext_sync   (ext_sync),
  .cf_reset   (cf_reset),
  .sc_en      (sc_en),
  .sc_pass    (sc_pass),
  .mc_line    (mc_line),
  .sc_line_ref(sc_line_ref),
  .mc_line_ref(mc_line_ref),
  .pd_drive   (pd_drive),
  .pd_oe      (pd_oe)
);

// File: tb/sclk_line_divider_tb.sv
`timescale 1ns/1ps
module sclk_line_divider_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sys_mode;
  logic       ext_sync, cf_reset, sc_en, mc_en;
  logic       sc_line_ref, mc_line_ref, pd_drive, pd_oe;

  always #2.5 clk = ~clk;

  sclk_line_divider #(.FIELD_LINES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .sys_mode(sys_mode), .ext_sync(ext_sync),
    .cf_reset(cf_reset), .sc_en(sc_en), .mc_en(mc_en),
    .sc_line_ref(sc_line_ref), .mc_line_ref(mc_line_ref),
    .pd_drive(pd_drive), .pd_oe(pd_oe)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] step;
    logic [15:0] norm;
    logic [15:0] fend;
    logic [15:0] mci;
  } vec_t;

  localparam int NVEC = 4;
  localparam vec_t VEC [NVEC] = '{
    '{2'b11, 16'd1, 16'd1135, 16'd1137, 16'd908},
    '{2'b11, 16'd2, 16'd2270, 16'd2274, 16'd908},
    '{2'b10, 16'd1, 16'd909,  16'd909,  16'd910},
    '{2'b10, 16'd3, 16'd2727, 16'd2727, 16'd910}
  };

  int n_chk = 0, n_fail = 0, cyc = 0;
  int sc_step = 0, mc_step = 0, sc_ph = 0, mc_ph = 0;
  int mstate = 0, pd_err = 0;
  int last_mc = -1, mc_int = 0, sc_cnt = 0, mc_cnt = 0, oe_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_en();
    sc_en = (sc_step != 0) && (sc_ph == 0);
    if (sc_step != 0) sc_ph = (sc_ph + 1) % sc_step;
    mc_en = (mc_step != 0) && (mc_ph == 0);
    if (mc_step != 0) mc_ph = (mc_ph + 1) % mc_step;
  endtask

  task automatic set_steps(input int s, input int m);
    sc_step = s; mc_step = m; sc_ph = 0; mc_ph = 0;
    apply_en();
  endtask

  // One clock: sample at the falling edge, model the comparator, drive enables.
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (!rst_n || sys_mode[1] == 1'b0 || ext_sync) mstate = 0;
    else begin
      case (mstate)
        0: if (sc_line_ref && !mc_line_ref) mstate = 1;
           else if (mc_line_ref && !sc_line_ref) mstate = 2;
        1: if (mc_line_ref) mstate = 0;
        2: if (sc_line_ref) mstate = 0;
        default: mstate = 0;
      endcase
    end
    if (pd_oe !== (mstate != 0) || pd_drive !== (mstate == 1)) pd_err++;
    if (sc_line_ref) sc_cnt++;
    if (mc_line_ref) begin
      mc_cnt++;
      if (last_mc >= 0) mc_int = cyc - last_mc;
      last_mc = cyc;
    end
    if (pd_oe) oe_cnt++;
    apply_en();
  endtask

  task automatic wait_sc(input int t0, output int d);
    int g = 0;
    do begin tick(); g++; end while (!sc_line_ref && g < 20000);
    d = cyc - t0;
  endtask

  task automatic wait_mc(input int t0, output int d);
    int g = 0;
    do begin tick(); g++; end while (!mc_line_ref && g < 20000);
    d = cyc - t0;
  endtask

  task automatic pulse_cf();
    cf_reset = 1'b1;
    tick();
    cf_reset = 1'b0;
  endtask

  initial begin
    #(190000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 190000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int t, d, c0, c1, o0;
    rst_n = 1'b0; sys_mode = 2'b11; ext_sync = 1'b0; cf_reset = 1'b0;
    sc_en = 1'b0; mc_en = 1'b0;
    repeat (4) tick();
    // R9: reset state
    check({sc_line_ref, mc_line_ref, pd_drive, pd_oe} == 4'b0, "R9 reset outputs",
          {sc_line_ref, mc_line_ref, pd_drive, pd_oe}, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    check({sc_line_ref, mc_line_ref, pd_oe} == 3'b0, "R9 idle after reset",
          {sc_line_ref, mc_line_ref, pd_oe}, 0);

    // Table: line intervals per mode and strobe rate (R1 R2 R3 R4)
    for (int i = 0; i < NVEC; i++) begin
      sys_mode = VEC[i].mode;
      set_steps(int'(VEC[i].step), 1);
      tick();
      pulse_cf();
      t = cyc; wait_sc(t, d);
      for (int k = 1; k <= 4; k++) begin
        t = cyc; wait_sc(t, d);
        if (k == 3)
          check(d == int'(VEC[i].fend), "R3 field-end interval", d, int'(VEC[i].fend));
        else if (VEC[i].mode == 2'b11)
          check(d == int'(VEC[i].norm), "R2 PAL line interval", d, int'(VEC[i].norm));
        else
          check(d == int'(VEC[i].norm), "R1 PAL-M line interval", d, int'(VEC[i].norm));
      end
      check(mc_int == int'(VEC[i].mci), "R4 master line interval", mc_int, int'(VEC[i].mci));
    end

    // R5: colour-frame restart, PAL and PAL-M
    sys_mode = 2'b11; set_steps(1, 1);
    tick(); t = cyc; pulse_cf(); wait_sc(t, d);
    check(d == 1135, "R5 PAL first line after cf_reset", d, 1135);
    sys_mode = 2'b10;
    tick(); t = cyc; pulse_cf(); wait_sc(t, d);
    check(d == 910, "R5 PAL-M first line after cf_reset", d, 910);

    // R6: external sync freezes counting
    sys_mode = 2'b11;
    tick(); pulse_cf(); t = cyc; wait_sc(t, d);
    t = cyc;
    repeat (200) tick();
    ext_sync = 1'b1;
    c0 = sc_cnt; c1 = mc_cnt; o0 = oe_cnt;
    repeat (100) tick();
    check(sc_cnt == c0 && mc_cnt == c1, "R6 no references while frozen",
          (sc_cnt - c0) + (mc_cnt - c1), 0);
    check(oe_cnt == o0 + 0 || oe_cnt == o0 + 1, "R6 comparator released", oe_cnt - o0, 0);
    check(pd_oe == 1'b0, "R6 pd_oe low while frozen", pd_oe, 0);
    ext_sync = 1'b0;
    wait_sc(t, d);
    check(d == 1235, "R6 counting resumes from held value", d, 1235);

    // R7 + R8: subcarrier leads
    sys_mode = 2'b00; set_steps(1, 1); tick(); tick();
    sys_mode = 2'b10; set_steps(1, 0);
    t = cyc; wait_sc(t, d);
    check(d == 909, "R8 sc chain held at zero in NTSC", d, 909);
    check(pd_oe == 1'b1 && pd_drive == 1'b1, "R7 drive high after sc edge",
          {pd_oe, pd_drive}, 3);
    repeat (50) tick();
    check(pd_oe == 1'b1 && pd_drive == 1'b1, "R7 high held until mc edge",
          {pd_oe, pd_drive}, 3);
    set_steps(1, 1);
    t = cyc; wait_mc(t, d);
    check(d == 910, "R8 master divider held at zero", d, 910);
    check(pd_oe == 1'b0, "R7 released at mc edge", pd_oe, 0);

    // R7: master leads
    sys_mode = 2'b00; set_steps(1, 1); tick(); tick();
    sys_mode = 2'b10; set_steps(0, 1);
    t = cyc; wait_mc(t, d);
    check(pd_oe == 1'b1 && pd_drive == 1'b0, "R7 drive low after mc edge",
          {pd_oe, pd_drive}, 2);
    repeat (50) tick();
    check(pd_oe == 1'b1 && pd_drive == 1'b0, "R7 low held until sc edge",
          {pd_oe, pd_drive}, 2);
    set_steps(1, 1);
    t = cyc; wait_sc(t, d);
    check(pd_oe == 1'b0, "R7 released at sc edge", pd_oe, 0);

    // R8: NTSC and SECAM stay idle
    sys_mode = 2'b00; set_steps(1, 1); tick();
    c0 = sc_cnt; c1 = mc_cnt; o0 = oe_cnt;
    repeat (1500) tick();
    check(sc_cnt == c0 && mc_cnt == c1 && oe_cnt == o0, "R8 NTSC idle",
          (sc_cnt - c0) + (mc_cnt - c1) + (oe_cnt - o0), 0);
    sys_mode = 2'b01; tick();
    c0 = sc_cnt; c1 = mc_cnt; o0 = oe_cnt;
    repeat (1500) tick();
    check(sc_cnt == c0 && mc_cnt == c1 && oe_cnt == o0, "R8 SECAM idle",
          (sc_cnt - c0) + (mc_cnt - c1) + (oe_cnt - o0), 0);

    // R7: cycle-by-cycle comparator model over the whole run
    check(pd_err == 0, "R7 comparator cycle mismatches", pd_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule